// File: doc/BRIEF.md
# Asynchronous HDLC Receive Event Collector

This block gathers receive-line conditions from an asynchronous HDLC channel and turns them into latched, maskable interrupt events. A receive deserializer and buffer manager sit upstream and report their results as single-cycle strobes. Those strobes are: a break character arrived, an idle bit was seen, a frame finished with its closing flag, the stop-bit midpoint of that flag passed, a frame was thrown away for lack of a buffer, a buffer completed, and clock glitches or transmit conditions occurred. The block keeps a small amount of state: whether a break sequence is in progress, the previous idle level, and a count of completed frames.

Software sees a 16-bit event word, a 16-bit mask word and a read-only status word. Event bits are cleared by writing ones. One interrupt line is raised whenever an event bit is set whose mask bit is also set. Both words use MSB-first numbering: bit n of the numbering sits at vector index 15-n.

Top module: `hdlcEvtTop`

## Requirements
- R1: Event bits live at vector indices 12 (receive clock glitch), 11 (transmit clock glitch), 8 (idle change), 6 (break end), 5 (break start), 4 (transmit error), 3 (frame threshold), 2 (busy/dropped frame), 1 (transmit buffer) and 0 (receive buffer); every other index of `evtReg` always reads 0.
- R2: A write with `wrEn`=1 and `wrSel`=0 clears each event bit whose `wrData` bit is 1, and leaves bits whose `wrData` bit is 0 untouched. If a set condition occurs in the same cycle as its clear, the bit stays set. An event bit appears in `evtReg` one clock after its cause.
- R3: Break start (index 5) is set on the first `brkCharStb` of a sequence only; further break characters do not set it again until the sequence has ended.
- R4: Break end (index 6) is set by `idleBitStb` while a break sequence is active; this ends the sequence and re-arms break start. An idle bit with no break in progress sets nothing.
- R5: Idle change (index 8) is set in the cycle after `lineIdle` differs from its value on the previous clock, with the previous value taken as 1 at reset. `statusReg[8]` follows `lineIdle` combinationally, and all other status bits are 0.
- R6: Each `frameDoneStb` counts a completed frame. When the count reaches `frameThresh` the counter returns to zero and a frame report is armed. A threshold of 0 behaves as 1.
- R7: The frame event (index 3) is set only by a `stopMidStb` while a report is armed, and doing so disarms it. A stop-bit strobe with nothing armed sets nothing.
- R8: `frameDropStb` sets the busy event (index 2).
- R9: `rxBufDoneStb` sets the receive-buffer event (index 0) only when `rxBufIntFlag`=1 and `rxBufLastFlag`=0.
- R10: `rxGlitchStb`, `txGlitchStb`, `txErrStb` and `txBufStb` set indices 12, 11, 4 and 1 respectively.
- R11: `irq` is 1 exactly when some bit is set in both `evtReg` and `maskReg`. Event and mask registers reset to zero.
- R12: A write with `wrEn`=1 and `wrSel`=1 loads `maskReg` from `wrData` at the valid indices only; reserved mask bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| brkCharStb | input | 1 | A break character was received |
| idleBitStb | input | 1 | An idle bit was detected |
| lineIdle | input | 1 | Real-time line idle level |
| frameDoneStb | input | 1 | Frame completed with closing flag |
| stopMidStb | input | 1 | Midpoint of closing-flag stop bit |
| frameDropStb | input | 1 | Frame discarded, no receive buffer |
| rxBufDoneStb | input | 1 | A receive buffer completed |
| rxBufIntFlag | input | 1 | Completed buffer requests an interrupt |
| rxBufLastFlag | input | 1 | Completed buffer is last of its frame |
| rxGlitchStb | input | 1 | Receive clock glitch |
| txGlitchStb | input | 1 | Transmit clock glitch |
| txErrStb | input | 1 | Transmit error |
| txBufStb | input | 1 | Transmit buffer sent |
| frameThresh | input | CNT_W | Frames per frame event |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 = event word, 1 = mask word |
| wrData | input | 16 | Write data |
| evtReg | output | 16 | Event word |
| maskReg | output | 16 | Mask word |
| statusReg | output | 16 | Real-time status word |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after long break sequences that are cleared partway through. A design that re-raises break start on every character would set the bit again after the clear. It also runs frame counts with thresholds of 0, 1 and 3, and changes the threshold while the counter holds frames. An off-by-one counter, or one that reports on the closing flag and does not wait for the stop-bit midpoint, shows up as a frame event one frame or a few cycles off. Clears that land on the same cycle as a new event catch a design where the clear wins. All-ones writes to the mask catch a design whose reserved bits are writable, and a design whose reserved bits could reach `irq` through them.

// File: rtl/hdlcEvtPkg.sv
package hdlcEvtPkg;
  localparam int EW = 16;

  // vector indices (MSB-first numbering n maps to index 15-n)
  localparam int IX_GLR  = 12;
  localparam int IX_GLT  = 11;
  localparam int IX_IDL  = 8;
  localparam int IX_BRKE = 6;
  localparam int IX_BRKS = 5;
  localparam int IX_TXE  = 4;
  localparam int IX_RXF  = 3;
  localparam int IX_BSY  = 2;
  localparam int IX_TXB  = 1;
  localparam int IX_RXB  = 0;
  localparam int IX_STAT_IDLE = 8;

  localparam logic [EW-1:0] VALID_MASK =
    (16'h1 << IX_GLR) | (16'h1 << IX_GLT) | (16'h1 << IX_IDL) |
    (16'h1 << IX_BRKE) | (16'h1 << IX_BRKS) | (16'h1 << IX_TXE) |
    (16'h1 << IX_RXF) | (16'h1 << IX_BSY) | (16'h1 << IX_TXB) |
    (16'h1 << IX_RXB);

  // strobes from control to datapath
  typedef struct packed {
    logic rxGlitch;
    logic txGlitch;
    logic idleChg;
    logic brkEnd;
    logic brkStart;
    logic txErr;
    logic rxFrame;
    logic busy;
    logic txBuf;
    logic rxBuf;
  } evtSetT;

  function automatic logic [EW-1:0] setToVec(input evtSetT s);
    logic [EW-1:0] v;
    v = '0;
    v[IX_GLR]  = s.rxGlitch;
    v[IX_GLT]  = s.txGlitch;
    v[IX_IDL]  = s.idleChg;
    v[IX_BRKE] = s.brkEnd;
    v[IX_BRKS] = s.brkStart;
    v[IX_TXE]  = s.txErr;
    v[IX_RXF]  = s.rxFrame;
    v[IX_BSY]  = s.busy;
    v[IX_TXB]  = s.txBuf;
    v[IX_RXB]  = s.rxBuf;
    return v;
  endfunction
endpackage

// File: rtl/hdlcEvtCtrl.sv
module hdlcEvtCtrl
  import hdlcEvtPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brkCharStb,
  input  logic             idleBitStb,
  input  logic             lineIdle,
  input  logic             frameDoneStb,
  input  logic             stopMidStb,
  input  logic             frameDropStb,
  input  logic             rxBufDoneStb,
  input  logic             rxBufIntFlag,
  input  logic             rxBufLastFlag,
  input  logic             rxGlitchStb,
  input  logic             txGlitchStb,
  input  logic             txErrStb,
  input  logic             txBufStb,
  input  logic [CNT_W-1:0] frameThresh,
  output evtSetT           evtSet
);
  localparam int CW = CNT_W + 1;

  logic          brkActive;
  logic          idlePrev;
  logic [CW-1:0] frameCnt;
  logic          rxfArmed;

  logic [CW-1:0] threshEff;
  logic [CW-1:0] cntPlusOne;
  logic          threshHit;
  logic          brkStartNow;
  logic          brkEndNow;

  // break sequence tracking
  assign brkStartNow = brkCharStb && !brkActive;
  assign brkEndNow   = idleBitStb && brkActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkActive <= 1'b0;
    end else if (brkEndNow) begin
      brkActive <= 1'b0;
    end else if (brkCharStb) begin
      brkActive <= 1'b1;
    end
  end

  // idle level history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idlePrev <= 1'b1;
    else       idlePrev <= lineIdle;
  end

  // frame threshold counter
  always_comb begin
    threshEff  = (frameThresh == '0) ? CW'(1) : CW'(frameThresh);
    cntPlusOne = frameCnt + CW'(1);
    threshHit  = frameDoneStb && (cntPlusOne >= threshEff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
    end else if (frameDoneStb) begin
      frameCnt <= threshHit ? '0 : cntPlusOne;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxfArmed <= 1'b0;
    else       rxfArmed <= (rxfArmed && !stopMidStb) || threshHit;
  end

  // strobe bundle
  always_comb begin
    evtSet          = '0;
    evtSet.rxGlitch = rxGlitchStb;
    evtSet.txGlitch = txGlitchStb;
    evtSet.idleChg  = lineIdle != idlePrev;
    evtSet.brkEnd   = brkEndNow;
    evtSet.brkStart = brkStartNow;
    evtSet.txErr    = txErrStb;
    evtSet.rxFrame  = rxfArmed && stopMidStb;
    evtSet.busy     = frameDropStb;
    evtSet.txBuf    = txBufStb;
    evtSet.rxBuf    = rxBufDoneStb && rxBufIntFlag && !rxBufLastFlag;
  end
endmodule

// File: rtl/hdlcEvtRegs.sv
module hdlcEvtRegs
  import hdlcEvtPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  evtSetT        evtSet,
  input  logic          lineIdle,
  input  logic          wrEn,
  input  logic          wrSel,
  input  logic [EW-1:0] wrData,
  output logic [EW-1:0] evtReg,
  output logic [EW-1:0] maskReg,
  output logic [EW-1:0] statusReg,
  output logic          irq
);
  logic [EW-1:0] setVec;
  logic [EW-1:0] clrVec;
  logic          maskWr;

  assign setVec = setToVec(evtSet);
  assign clrVec = (wrEn && !wrSel) ? wrData : '0;
  assign maskWr = wrEn && wrSel;

  for (genvar i = 0; i < EW; i++) begin : g_bit
    if (VALID_MASK[i]) begin : g_live
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          evtReg[i] <= 1'b0;
        end else if (setVec[i]) begin
          evtReg[i] <= 1'b1;
        end else if (clrVec[i]) begin
          evtReg[i] <= 1'b0;
        end
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       maskReg[i] <= 1'b0;
        else if (maskWr) maskReg[i] <= wrData[i];
      end
    end else begin : g_rsvd
      assign evtReg[i]  = 1'b0;
      assign maskReg[i] = 1'b0;
    end
  end

  always_comb begin
    statusReg               = '0;
    statusReg[IX_STAT_IDLE] = lineIdle;
  end

  assign irq = |(evtReg & maskReg);
endmodule

// File: rtl/hdlcEvtTop.sv
module hdlcEvtTop
  import hdlcEvtPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brkCharStb,
  input  logic             idleBitStb,
  input  logic             lineIdle,
  input  logic             frameDoneStb,
  input  logic             stopMidStb,
  input  logic             frameDropStb,
  input  logic             rxBufDoneStb,
  input  logic             rxBufIntFlag,
  input  logic             rxBufLastFlag,
  input  logic             rxGlitchStb,
  input  logic             txGlitchStb,
  input  logic             txErrStb,
  input  logic             txBufStb,
  input  logic [CNT_W-1:0] frameThresh,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [15:0]      wrData,
  output logic [15:0]      evtReg,
  output logic [15:0]      maskReg,
  output logic [15:0]      statusReg,
  output logic             irq
);
  evtSetT evtSet;

  hdlcEvtCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .brkCharStb   (brkCharStb),
    .idleBitStb   (idleBitStb),
    .lineIdle     (lineIdle),
    .frameDoneStb (frameDoneStb),
    .stopMidStb   (stopMidStb),
    .frameDropStb (frameDropStb),
    .rxBufDoneStb (rxBufDoneStb),
    .rxBufIntFlag (rxBufIntFlag),
    .rxBufLastFlag(rxBufLastFlag),
    .rxGlitchStb  (rxGlitchStb),
    .txGlitchStb  (txGlitchStb),
    .txErrStb     (txErrStb),
    .txBufStb     (txBufStb),
    .frameThresh  (frameThresh),
    .evtSet       (evtSet)
  );

  hdlcEvtRegs uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .evtSet   (evtSet),
    .lineIdle (lineIdle),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .evtReg   (evtReg),
    .maskReg  (maskReg),
    .statusReg(statusReg),
    .irq      (irq)
  );
endmodule

// File: rtl/hdlcEvtChecker.sv
module hdlcEvtChecker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             brkCharStb,
  input logic             idleBitStb,
  input logic             lineIdle,
  input logic             frameDoneStb,
  input logic             stopMidStb,
  input logic             frameDropStb,
  input logic             rxBufDoneStb,
  input logic             rxBufIntFlag,
  input logic             rxBufLastFlag,
  input logic             rxGlitchStb,
  input logic             txGlitchStb,
  input logic             txErrStb,
  input logic             txBufStb,
  input logic [CNT_W-1:0] frameThresh,
  input logic             wrEn,
  input logic             wrSel,
  input logic [15:0]      wrData,
  input logic [15:0]      evtReg,
  input logic [15:0]      maskReg,
  input logic [15:0]      statusReg,
  input logic             irq
);
  // R1
  rsvd_evt_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtReg & 16'hE680) == 16'h0);

  // R12
  rsvd_mask_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg & 16'hE680) == 16'h0);

  // R2
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameDropStb && wrEn && !wrSel && wrData[2]) |=> evtReg[2]);

  // R2
  clear_works_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameDropStb && wrEn && !wrSel && wrData[2]) |=> !evtReg[2]);

  // R3
  no_second_brks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkCharStb && !idleBitStb) ##1
    (brkCharStb && !idleBitStb && wrEn && !wrSel && wrData[5]) |=> !evtReg[5]);

  // R7
  rxf_at_midpoint_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtReg[3]) |-> $past(stopMidStb));

  // R8
  busy_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDropStb |=> evtReg[2]);

  // R5
  status_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusReg == {7'b0, lineIdle, 8'b0});

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == ((evtReg & maskReg) != 16'h0));
endmodule

bind hdlcEvtTop hdlcEvtChecker #(.CNT_W(CNT_W)) uChk (.*);

// File: tb/hdlcEvtTop_test.sv
module hdlcEvtTop_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic brkCharStb = 0, idleBitStb = 0, lineIdle = 1, frameDoneStb = 0;
  logic stopMidStb = 0, frameDropStb = 0, rxBufDoneStb = 0, rxBufIntFlag = 0;
  logic rxBufLastFlag = 0, rxGlitchStb = 0, txGlitchStb = 0, txErrStb = 0;
  logic txBufStb = 0;
  logic [CNT_W-1:0] frameThresh = 8'd1;
  logic wrEn = 0, wrSel = 0;
  logic [15:0] wrData = 16'h0;
  logic [15:0] evtReg, maskReg, statusReg;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hdlcEvtTop #(.CNT_W(CNT_W)) uut (.*);

  // reference model state
  logic [15:0] mEvt = 0, mMask = 0;
  bit mBrk = 0, mPrevIdle = 1, mArmed = 0;
  int mCnt = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mEvt = 0; mMask = 0; mBrk = 0; mPrevIdle = 1; mArmed = 0; mCnt = 0;
    end else begin
      logic [15:0] s;
      int th;
      bit hit;
      s = 0;
      if (rxGlitchStb) s[12] = 1;
      if (txGlitchStb) s[11] = 1;
      if (lineIdle != mPrevIdle) s[8] = 1;
      if (idleBitStb && mBrk) s[6] = 1;
      if (brkCharStb && !mBrk) s[5] = 1;
      if (txErrStb) s[4] = 1;
      if (stopMidStb && mArmed) s[3] = 1;
      if (frameDropStb) s[2] = 1;
      if (txBufStb) s[1] = 1;
      if (rxBufDoneStb && rxBufIntFlag && !rxBufLastFlag) s[0] = 1;
      th = (frameThresh == 0) ? 1 : int'(frameThresh);
      hit = 0;
      if (frameDoneStb) begin
        mCnt++;
        if (mCnt >= th) begin mCnt = 0; hit = 1; end
      end
      mArmed = (mArmed && !stopMidStb) || hit;
      if (idleBitStb && mBrk) mBrk = 0;
      else if (brkCharStb) mBrk = 1;
      mPrevIdle = lineIdle;
      if (wrEn && !wrSel) mEvt = mEvt & ~wrData;
      if (wrEn && wrSel) mMask = wrData & 16'h197F;
      mEvt = mEvt | s;
    end
  end

  function automatic string tagOf(int i);
    case (i)
      12, 11, 4, 1: return "R10";
      8: return "R5";
      6: return "R4";
      5: return "R3";
      3: return "R7";
      2: return "R8";
      0: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int i = 0; i < 16; i++) chk(16'(evtReg[i]), 16'(mEvt[i]), tagOf(i));
      chk(maskReg, mMask, "R12");
      chk(16'(irq), 16'((mEvt & mMask) != 0), "R11");
      chk(statusReg, {7'b0, lineIdle, 8'b0}, "R5");
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    brkCharStb = 0; idleBitStb = 0; frameDoneStb = 0; stopMidStb = 0;
    frameDropStb = 0; rxBufDoneStb = 0; rxGlitchStb = 0; txGlitchStb = 0;
    txErrStb = 0; txBufStb = 0; wrEn = 0;
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    wrEn = 1; wrSel = sel; wrData = d; tick();
  endtask

  task automatic frames(input int n);
    for (int k = 0; k < n; k++) begin
      frameDoneStb = 1; tick();
      tick();
      stopMidStb = 1; tick();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    tick();
    // R11 reset state then mask (R12 reserved ignored)
    chk(evtReg, 16'h0, "R11");
    chk(16'(irq), 16'h0, "R11");
    wr(1, 16'hFFFF);
    chk(maskReg, 16'h197F, "R12");
    // R10 pass-through events
    rxGlitchStb = 1; tick();
    txGlitchStb = 1; txErrStb = 1; tick();
    txBufStb = 1; tick();
    chk(evtReg, 16'h1812, "R10");
    wr(0, 16'hFFFF);
    chk(evtReg, 16'h0, "R2");
    // R3 / R4 long break sequence
    for (int k = 0; k < 6; k++) begin
      brkCharStb = 1;
      if (k == 2) begin wrEn = 1; wrSel = 0; wrData = 16'h0020; end
      tick();
    end
    chk(16'(evtReg[5]), 16'h0, "R3");
    idleBitStb = 1; tick();
    chk(16'(evtReg[6]), 16'h1, "R4");
    idleBitStb = 1; tick();
    brkCharStb = 1; tick();
    chk(16'(evtReg[5]), 16'h1, "R3");
    idleBitStb = 1; tick();
    wr(0, 16'h0060);
    // R5 idle toggles
    lineIdle = 0; tick(); tick();
    chk(16'(evtReg[8]), 16'h1, "R5");
    wr(0, 16'h0100);
    lineIdle = 1; tick();
    // R6 / R7 threshold 3
    frameThresh = 3;
    stopMidStb = 1; tick();
    frames(2);
    chk(16'(evtReg[3]), 16'h0, "R6");
    frames(1);
    chk(16'(evtReg[3]), 16'h1, "R7");
    wr(0, 16'h0008);
    frameThresh = 0;
    frameDoneStb = 1; tick(); tick();
    chk(16'(evtReg[3]), 16'h0, "R7");
    stopMidStb = 1; tick();
    chk(16'(evtReg[3]), 16'h1, "R6");
    // R8 busy with clear collision (R2)
    frameDropStb = 1; wrEn = 1; wrSel = 0; wrData = 16'h0004; tick();
    chk(16'(evtReg[2]), 16'h1, "R2");
    // R9 buffer variants
    wr(0, 16'hFFFF);
    rxBufDoneStb = 1; rxBufIntFlag = 1; rxBufLastFlag = 1; tick();
    rxBufDoneStb = 1; rxBufIntFlag = 0; rxBufLastFlag = 0; tick();
    chk(16'(evtReg[0]), 16'h0, "R9");
    rxBufDoneStb = 1; rxBufIntFlag = 1; rxBufLastFlag = 0; tick();
    chk(16'(evtReg[0]), 16'h1, "R9");
    // mixed traffic compared every cycle
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      brkCharStb = r[0] & r[1]; idleBitStb = r[2] & r[3];
      lineIdle = (r[4] & r[5]) ? ~lineIdle : lineIdle;
      frameDoneStb = r[6]; stopMidStb = r[7] & r[8];
      frameDropStb = r[9] & r[10]; rxBufDoneStb = r[11];
      rxBufIntFlag = r[12]; rxBufLastFlag = r[13];
      rxGlitchStb = r[14] & r[15]; txErrStb = r[16] & r[17];
      if (r[20:18] == 0) frameThresh = 8'(r[23:21]);
      if (r[26:24] == 0) begin wrEn = 1; wrSel = r[27]; wrData = r[31:16]; end
      tick();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      done = 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule